// File: doc/BRIEF.md
# ADC Output Word Mapper and Lane Serializer

This block takes one conversion beat carrying a 14-bit sample for each of two channels, widens every sample to an output word of 14, 16, 18 or 20 bits, and shifts the words out MSB first on four double-data-rate lanes. The design clock runs at the lane bit rate. Each cycle is one lane bit, which is one edge of the emitted bit clock. Lanes 0 and 1 belong to channel A and lanes 2 and 3 to channel B. Next to the lanes the block drives a frame clock that marks the word boundaries.

The samples come in on a valid/ready stream. A single holding register sits behind `s_ready`. The sender may present a beat at any time. The beat is taken on the first edge where `s_valid` and `s_ready` are both high. `s_ready` then stays low until the serializer moves the held beat into its output words at the next sample slot. Back-pressure therefore never stalls the lanes. A sender that does not refill the register within one sample period causes a zero word to be sent for that slot. Resolution and lane mode are static inputs. They are staged by a one-cycle `resync` pulse and only take hold at a frame boundary.

Top module: `adc_lane_serializer`

## Requirements
- R1: After reset, `s_ready` is high, `frame_clk` is high, `bit_clk` is low and all lanes are low. The active setting is 14-bit resolution in dual-lane mode, so the first frame lasts 14 cycles.
- R2: The output word of width W puts the 14-bit sample in its top bits. The W-14 bits below it are the top bits of the 6-bit extension field when `s_dec` is 1, and zero when `s_dec` is 0. `cfg_res` codes 0, 1, 2 and 3 give W = 14, 16, 18 and 20.
- R3: In dual-lane mode (`cfg_lanes` = 0), a frame lasts W cycles and carries two consecutive samples of W/2 cycles each. The odd word bits W-1, W-3, … go out on the upper lane of the channel pair (lane 1 for A, lane 3 for B). The even bits W-2, W-4, … go out on the lower lane (lane 0 for A, lane 2 for B).
- R4: In single-lane mode (`cfg_lanes` = 1), a frame lasts W cycles. Channel A goes out MSB first on lane 0 and channel B on lane 2. Lanes 1 and 3 stay low.
- R5: In shared-lane mode (`cfg_lanes` = 2), a frame lasts 2W cycles. Lane 0 carries the channel A word and then the channel B word. Lanes 1 to 3 stay low.
- R6: `frame_clk` is high for the first half of every frame and low for the second half. `bit_clk` toggles every cycle and is low in the first cycle of each frame.
- R7: `s_ready` is high exactly when the holding register is empty. A beat is taken when `s_valid` and `s_ready` are both high. Each sample slot loads the held beat, or a zero word for both channels if the register is empty. Beats are sent in the order they were taken, each exactly once.
- R8: Values on `cfg_res` and `cfg_lanes` have no effect without a `resync` pulse. After a pulse, the frame in progress finishes with its old length, and the new setting applies from the next frame boundary.
- R9: `cfg_lanes` code 3 behaves as single-lane mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Holding register empty |
| s_dec | input | 1 | Beat comes from the decimation path |
| s_data_a | input | 14 | Channel A sample |
| s_ext_a | input | 6 | Channel A filter extension bits |
| s_data_b | input | 14 | Channel B sample |
| s_ext_b | input | 6 | Channel B filter extension bits |
| cfg_res | input | 2 | Resolution code (14/16/18/20 bits) |
| cfg_lanes | input | 2 | Lane mode code |
| resync | input | 1 | Stage the configuration for the next frame |
| frame_clk | output | 1 | Frame clock |
| bit_clk | output | 1 | DDR bit clock |
| lane_o | output | 4 | Serial lanes, A on 0/1, B on 2/3 |

## Verification
The hardest case to reach is a configuration change that lands mid-frame, while the old frame is still being sent. The stimulus waits for a frame clock rising edge, waits three more cycles, then changes both codes and pulses `resync`. It then measures the length of the current frame and of the next one. The bench also stops the sample stream before each mode starts, so the first slot of every captured run is known to be empty. This lets the deserializer align on exact slot numbers and check the zero words, the sample order and the padding in each of the thirteen settings.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;

  localparam int N_CH      = 2;
  localparam int LANES     = 2 * N_CH;
  localparam int RES_STEP  = 2;
  localparam int RES_CODES = 4;
  localparam int EXT_W     = RES_STEP * (RES_CODES - 1);

  typedef enum logic [1:0] {
    LM_DUAL   = 2'd0,
    LM_SINGLE = 2'd1,
    LM_SHARED = 2'd2
  } lane_mode_e;

  // code 3 falls back to single-lane operation
  function automatic lane_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd0:    return LM_DUAL;
      2'd2:    return LM_SHARED;
      default: return LM_SINGLE;
    endcase
  endfunction

endpackage

// File: rtl/ls_bit_mapper.sv
module ls_bit_mapper
  import lane_ser_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  localparam int MAX_W   = SAMPLE_W + EXT_W
) (
  input  logic [SAMPLE_W-1:0] data,
  input  logic [EXT_W-1:0]    ext,
  input  logic                dec,
  input  logic [1:0]          res,
  output logic [MAX_W-1:0]    word
);

  logic [MAX_W-1:0] full;
  logic [MAX_W-1:0] keep;

  always_comb begin
    full = {data, (dec ? ext : {EXT_W{1'b0}})};
    keep = {MAX_W{1'b1}} << (EXT_W - RES_STEP * int'(res));
    word = full & keep;
  end

endmodule

// File: rtl/ls_frame_timer.sv
module ls_frame_timer
  import lane_ser_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       res_in,
  input  logic [1:0]       mode_in,
  input  logic             resync,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] width_o,
  output logic [1:0]       res_o,
  output lane_mode_e       mode_o,
  output logic [1:0]       res_next_o,
  output logic             load_o,
  output logic             frame_clk_o,
  output logic             bit_clk_o
);

  logic [CNT_W-1:0] pos_q;
  logic [1:0]       res_q;
  lane_mode_e       mode_q;
  logic             pending_q;

  logic [CNT_W-1:0] width, flen;
  logic             wrap, mid, take;

  always_comb begin
    width = CNT_W'(SAMPLE_W + RES_STEP * int'(res_q));
    flen  = (mode_q == LM_SHARED) ? (width << 1) : width;
    wrap  = (pos_q == flen - CNT_W'(1));
    mid   = (mode_q == LM_DUAL) && (pos_q == (width >> 1) - CNT_W'(1));
    take  = wrap && (pending_q || resync);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      res_q     <= '0;
      mode_q    <= LM_DUAL;
      pending_q <= 1'b0;
    end else begin
      pos_q     <= wrap ? '0 : pos_q + CNT_W'(1);
      pending_q <= wrap ? 1'b0 : (pending_q | resync);
      if (take) begin
        res_q  <= res_in;
        mode_q <= decode_mode(mode_in);
      end
    end
  end

  assign pos_o       = pos_q;
  assign width_o     = width;
  assign res_o       = res_q;
  assign mode_o      = mode_q;
  assign res_next_o  = take ? res_in : res_q;
  assign load_o      = wrap | mid;
  assign frame_clk_o = (pos_q < (flen >> 1));
  assign bit_clk_o   = pos_q[0];

endmodule

// File: rtl/ls_lane_mux.sv
module ls_lane_mux
  import lane_ser_pkg::*;
#(
  parameter int MAX_W = 20,
  parameter int CNT_W = 6,
  localparam int IDX_W = $clog2(MAX_W)
) (
  input  logic [MAX_W-1:0] word_a,
  input  logic [MAX_W-1:0] word_b,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] width,
  input  lane_mode_e       mode,
  output logic [LANES-1:0] lanes
);

  logic [MAX_W-1:0] w [N_CH];
  assign w[0] = word_a;
  assign w[1] = word_b;

  always_comb begin
    int k, hi, seq;
    lanes = '0;
    k   = (pos >= (width >> 1)) ? int'(pos - (width >> 1)) : int'(pos);
    hi  = MAX_W - 1 - 2 * k;
    seq = MAX_W - 1 - int'(pos);
    case (mode)
      LM_DUAL: begin
        for (int c = 0; c < N_CH; c++) begin
          lanes[2*c+1] = w[c][IDX_W'(hi)];
          lanes[2*c]   = w[c][IDX_W'(hi - 1)];
        end
      end
      LM_SHARED: begin
        if (pos < width) lanes[0] = w[0][IDX_W'(seq)];
        else             lanes[0] = w[1][IDX_W'(seq + int'(width))];
      end
      default: begin
        for (int c = 0; c < N_CH; c++) lanes[2*c] = w[c][IDX_W'(seq)];
      end
    endcase
  end

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic                s_dec,
  input  logic [SAMPLE_W-1:0] s_data_a,
  input  logic [EXT_W-1:0]    s_ext_a,
  input  logic [SAMPLE_W-1:0] s_data_b,
  input  logic [EXT_W-1:0]    s_ext_b,
  input  logic [1:0]          cfg_res,
  input  logic [1:0]          cfg_lanes,
  input  logic                resync,
  output logic                frame_clk,
  output logic                bit_clk,
  output logic [LANES-1:0]    lane_o
);

  localparam int MAX_W = SAMPLE_W + EXT_W;
  localparam int CNT_W = $clog2(2 * MAX_W + 1);

  logic [SAMPLE_W-1:0] in_data [N_CH];
  logic [EXT_W-1:0]    in_ext  [N_CH];
  logic [SAMPLE_W-1:0] h_data  [N_CH];
  logic [EXT_W-1:0]    h_ext   [N_CH];
  logic [MAX_W-1:0]    mapped  [N_CH];
  logic [MAX_W-1:0]    word_q  [N_CH];
  logic                h_dec, h_full;

  logic [CNT_W-1:0] pos, width;
  logic [1:0]       res_act, res_next;
  lane_mode_e       mode_act;
  logic             load_w;
  logic             accept;

  assign in_data[0] = s_data_a;
  assign in_data[1] = s_data_b;
  assign in_ext[0]  = s_ext_a;
  assign in_ext[1]  = s_ext_b;

  assign s_ready = !h_full;
  assign accept  = s_valid && s_ready;

  ls_frame_timer #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .res_in     (cfg_res),
    .mode_in    (cfg_lanes),
    .resync     (resync),
    .pos_o      (pos),
    .width_o    (width),
    .res_o      (res_act),
    .mode_o     (mode_act),
    .res_next_o (res_next),
    .load_o     (load_w),
    .frame_clk_o(frame_clk),
    .bit_clk_o  (bit_clk)
  );

  always_ff @(posedge clk) begin
    if (rst) h_full <= 1'b0;
    else if (load_w && h_full) h_full <= 1'b0;
    else if (accept) h_full <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) h_dec <= s_dec;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (accept) begin
        h_data[c] <= in_data[c];
        h_ext[c]  <= in_ext[c];
      end
    end

    ls_bit_mapper #(.SAMPLE_W(SAMPLE_W)) u_map (
      .data(h_data[c]),
      .ext (h_ext[c]),
      .dec (h_dec),
      .res (res_next),
      .word(mapped[c])
    );

    always_ff @(posedge clk) begin
      if (rst) word_q[c] <= '0;
      else if (load_w) word_q[c] <= h_full ? mapped[c] : '0;
    end
  end

  ls_lane_mux #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_mux (
    .word_a(word_q[0]),
    .word_b(word_q[1]),
    .pos   (pos),
    .width (width),
    .mode  (mode_act),
    .lanes (lane_o)
  );

endmodule

// File: rtl/ls_serializer_chk.sv
module ls_serializer_chk
  import lane_ser_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic             frame_clk,
  input logic             bit_clk,
  input logic [LANES-1:0] lanes,
  input lane_mode_e       mode_act,
  input logic [1:0]       res_act,
  input logic [CNT_W-1:0] pos,
  input logic             load
);

  assert_accept_fills_R7: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  assert_ready_held_R7: assert property (@(posedge clk) disable iff (rst)
    (!s_ready && !load) |=> !s_ready);

  assert_frame_start_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_clk) |-> !bit_clk);

  assert_bit_clk_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (pos != '0) |-> (bit_clk != $past(bit_clk)));

  assert_upper_lanes_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_act != LM_DUAL) |-> (lanes[1] == 1'b0 && lanes[3] == 1'b0));

  assert_shared_lane_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_act == LM_SHARED) |-> (lanes[2] == 1'b0));

  assert_cfg_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable({mode_act, res_act}) |-> (pos == '0));

endmodule

bind adc_lane_serializer ls_serializer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .frame_clk(frame_clk),
  .bit_clk  (bit_clk),
  .lanes    (lane_o),
  .mode_act (mode_act),
  .res_act  (res_act),
  .pos      (pos),
  .load     (load_w)
);

// File: tb/adc_lane_serializer_test.sv
module adc_lane_serializer_test;

  localparam int NS   = 5;
  localparam int NSLT = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0, s_dec = 1'b0, resync = 1'b0;
  logic [13:0] s_data_a = '0, s_data_b = '0;
  logic [5:0]  s_ext_a = '0, s_ext_b = '0;
  logic [1:0]  cfg_res = '0, cfg_lanes = '0;
  logic        s_ready, frame_clk, bit_clk;
  logic [3:0]  lane_o;

  int n_checks = 0;
  int n_fails  = 0;

  logic [13:0] sda [NS];
  logic [13:0] sdb [NS];
  logic [5:0]  sea [NS];
  logic [5:0]  seb [NS];
  logic        sdc [NS];
  logic [3:0]  cap [400];

  adc_lane_serializer uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_dec(s_dec),
    .s_data_a(s_data_a), .s_ext_a(s_ext_a), .s_data_b(s_data_b), .s_ext_b(s_ext_b),
    .cfg_res(cfg_res), .cfg_lanes(cfg_lanes), .resync(resync),
    .frame_clk(frame_clk), .bit_clk(bit_clk), .lane_o(lane_o)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int wid(input int res);
    return 14 + 2 * res;
  endfunction

  function automatic int flen(input int res, input int mode);
    return (mode == 2) ? 2 * wid(res) : wid(res);
  endfunction

  function automatic logic [19:0] exp_word(input logic [13:0] d, input logic [5:0] e,
                                           input logic dec, input int res);
    logic [19:0] full;
    full = {d, (dec ? e : 6'b0)};
    return full >> (6 - 2 * res);
  endfunction

  function automatic logic [19:0] decode(input int s, input int ch, input int res, input int mode);
    logic [19:0] w;
    int W, base;
    W = wid(res);
    w = '0;
    if (mode == 0) begin
      base = s * (W / 2);
      for (int k = 0; k < W / 2; k++) begin
        w[W-1-2*k] = cap[base+k][2*ch+1];
        w[W-2-2*k] = cap[base+k][2*ch];
      end
    end else if (mode == 2) begin
      base = s * 2 * W + ch * W;
      for (int k = 0; k < W; k++) w[W-1-k] = cap[base+k][0];
    end else begin
      base = s * W;
      for (int k = 0; k < W; k++) w[W-1-k] = cap[base+k][2*ch];
    end
    return w;
  endfunction

  task automatic wait_frame_start();
    logic p;
    @(negedge clk);
    p = frame_clk;
    forever begin
      @(negedge clk);
      if (frame_clk && !p) break;
      p = frame_clk;
    end
  endtask

  // called at the first cycle of a frame; returns at the first cycle of the next one
  task automatic measure_frame(output int n);
    logic p;
    n = 0;
    p = frame_clk;
    forever begin
      @(negedge clk);
      n++;
      if (frame_clk && !p) break;
      p = frame_clk;
    end
  endtask

  task automatic reconfigure(input int res, input int mode);
    @(negedge clk);
    cfg_res = 2'(res);
    cfg_lanes = 2'(mode);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic feed();
    for (int i = 0; i < NS; i++) begin
      s_valid = 1'b1;
      s_data_a = sda[i]; s_ext_a = sea[i];
      s_data_b = sdb[i]; s_ext_b = seb[i];
      s_dec = sdc[i];
      forever begin
        if (s_ready) begin
          @(posedge clk);
          break;
        end
        @(negedge clk);
      end
      @(negedge clk);
      check(s_ready == 1'b0, "R7 ready low after accept", 32'(s_ready), 0);
    end
    s_valid = 1'b0;
  endtask

  task automatic capture(input int nfr, input int res, input int mode);
    int idx, FL, tbad, ibad;
    string itag;
    idx = 0;
    FL = flen(res, mode);
    itag = (mode == 2) ? "R5 idle lanes" : "R4 idle lanes";
    for (int f = 0; f < nfr; f++) begin
      tbad = 0; ibad = 0;
      for (int c = 0; c < FL; c++) begin
        cap[idx] = lane_o;
        if (frame_clk !== (c < FL / 2)) tbad++;
        if (bit_clk !== 1'(c % 2)) tbad++;
        if (mode != 0 && (lane_o[1] !== 1'b0 || lane_o[3] !== 1'b0)) ibad++;
        if (mode == 2 && lane_o[2] !== 1'b0) ibad++;
        idx++;
        @(negedge clk);
      end
      check(frame_clk === 1'b1 && tbad == 0, "R6 frame/bit clock pattern", 32'(tbad), 0);
      if (mode != 0) check(ibad == 0, itag, 32'(ibad), 0);
    end
  endtask

  task automatic run_combo(input int res, input int mode, input int seed);
    string tag;
    logic [19:0] ea, eb, ga, gb;
    reconfigure(res, mode);
    for (int i = 0; i < NS; i++) begin
      sda[i] = 14'((seed * 1237 + i * 4099 + 5) & 16'h3fff) | 14'h0001;
      sdb[i] = (sda[i] ^ 14'h2aaa) | 14'h0100;
      sea[i] = 6'((seed * 7 + i * 13) & 6'h1f) | 6'h20;
      seb[i] = 6'((seed * 11 + i * 5) & 6'h0f) | 6'h30;
      sdc[i] = 1'(i % 2);
    end
    case (mode)
      0: tag = "R2 R3 dual-lane word";
      1: tag = "R2 R4 single-lane word";
      2: tag = "R2 R5 shared-lane word";
      default: tag = "R9 code-3 word";
    endcase
    wait_frame_start();
    fork
      feed();
      capture((mode == 0) ? NSLT / 2 : NSLT, res, mode);
    join
    for (int s = 0; s < NSLT; s++) begin
      if (s >= 1 && s <= NS) begin
        ea = exp_word(sda[s-1], sea[s-1], sdc[s-1], res);
        eb = exp_word(sdb[s-1], seb[s-1], sdc[s-1], res);
      end else begin
        ea = '0; eb = '0;
      end
      ga = decode(s, 0, res, mode);
      gb = decode(s, 1, res, mode);
      if (s >= 1 && s <= NS) begin
        check(ga == ea, tag, 32'(ga), 32'(ea));
        check(gb == eb, tag, 32'(gb), 32'(eb));
      end else begin
        check(ga == 0 && gb == 0, "R7 empty slot sends zero", 32'(ga | gb), 0);
      end
    end
  endtask

  task automatic test_reset();
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check(s_ready === 1'b1, "R1 ready after reset", 32'(s_ready), 1);
    check(frame_clk === 1'b1 && bit_clk === 1'b0, "R1 clocks after reset",
          32'({frame_clk, bit_clk}), 32'h2);
    check(lane_o === 4'b0, "R1 lanes after reset", 32'(lane_o), 0);
    measure_frame(n);
    check(n == 14, "R1 default frame length", 32'(n), 14);
  endtask

  task automatic test_no_resync();
    int n;
    wait_frame_start();
    cfg_res = 2'd0;
    cfg_lanes = 2'd2;
    measure_frame(n);
    check(n == 20, "R8 no resync keeps length", 32'(n), 20);
    measure_frame(n);
    check(n == 20, "R8 no resync keeps length", 32'(n), 20);
  endtask

  task automatic test_boundary();
    int n;
    logic p;
    wait_frame_start();
    repeat (3) @(negedge clk);
    cfg_res = 2'd1;
    cfg_lanes = 2'd2;
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    n = 4;
    p = frame_clk;
    forever begin
      @(negedge clk);
      n++;
      if (frame_clk && !p) break;
      p = frame_clk;
    end
    check(n == 20, "R8 current frame keeps old length", 32'(n), 20);
    measure_frame(n);
    check(n == 32, "R8 next frame uses new setting", 32'(n), 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    test_reset();
    for (int m = 0; m < 3; m++)
      for (int r = 0; r < 4; r++)
        run_combo(r, m, m * 4 + r + 1);
    run_combo(3, 3, 21);
    test_no_resync();
    test_boundary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule